// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the operand address for a load/store style pipeline stage. It receives up to three address terms: a base register value, an index register value shifted left by 0 to 3 bits, and a signed displacement of one, two or four bytes. It adds them modulo 2^32 and registers the sum. Any of the terms may be absent. An index field that names register 4 (the stack pointer) is treated as having no index.

Each operation is either a memory access or an address-only computation. A memory access raises a memory-request strobe together with the address. An address-only operation returns the sum as a write-back value and never raises the memory strobe. Register file reads happen upstream: the block only sees the register values it is handed. The result appears one clock after the inputs are presented.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted, and in any cycle whose `out_valid` is low, `out_valid`, `mem_req` and `wb_en` are all 0.
- R2: When `in_valid` is high at a rising clock edge, `out_valid` is 1 after that edge and `ea_out` holds displacement + base + (index << scale). When `in_valid` is low, `out_valid` is 0 after the edge.
- R3: A term that is absent contributes zero. The base is absent when `base_en`=0, the index is absent when `index_en`=0, and the displacement is absent when `disp_size`=00. The value on the input of an absent term has no effect.
- R4: `disp_size` selects the displacement. 01 takes `disp_raw[7:0]` sign-extended, 10 takes `disp_raw[15:0]` sign-extended, and 11 takes all 32 bits. Bits above the selected width are ignored.
- R5: `scale_code` 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8 respectively.
- R6: When `index_sel` equals 4, the index contributes zero even if `index_en`=1.
- R7: For `op_kind`=0 (memory access), the result cycle has `mem_req`=1 and `wb_en`=0.
- R8: For `op_kind`=1 (address-only), the result cycle has `wb_en`=1, `mem_req`=0, and `wb_val` equal to the computed sum.
- R9: `mem_req` and `wb_en` are never high in the same cycle, so each operation produces at most one memory address.
- R10: The sum wraps modulo 2^32 with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_kind | input | 1 | 0 memory access, 1 address-only |
| base_en | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| index_en | input | 1 | Index term present |
| index_sel | input | 3 | Index register number (4 means no index) |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount 0..3 |
| disp_size | input | 2 | 00 none, 01 byte, 10 half, 11 word |
| disp_raw | input | 32 | Raw displacement bits |
| out_valid | output | 1 | Result valid |
| ea_out | output | 32 | Effective address |
| mem_req | output | 1 | Memory request strobe |
| wb_en | output | 1 | Write-back of address-only result |
| wb_val | output | 32 | Address-only result |

## Verification
The clocked checks assume that `in_valid` is held low during reset, so that the first cycle after reset starts idle. They also assume that `op_kind` is a known value whenever `in_valid` is high. The bench drives every input on the falling edge and keeps `in_valid` at 0 throughout reset, including a reset applied in the middle of the run. The combinational checks on the shifter and the sign extender depend only on the current code inputs, and the vectors step through every scale code and every displacement size.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic {
      OP_MEM  = 1'b0,
      OP_ADDR = 1'b1
   } op_kind_e;

   typedef enum logic [1:0] {
      DSZ_NONE = 2'b00,
      DSZ_BYTE = 2'b01,
      DSZ_HALF = 2'b10,
      DSZ_WORD = 2'b11
   } disp_size_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        size_code,
   input  logic [ADDR_W-1:0] raw,
   output logic [ADDR_W-1:0] ext
);
   import ea_pkg::*;

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("ea_disp_ext: ADDR_W must be at least 16");
      end
   endgenerate

   always_comb begin
      unique case (disp_size_e'(size_code))
         DSZ_NONE: ext = '0;
         DSZ_BYTE: ext = {{(ADDR_W-8){raw[7]}}, raw[7:0]};
         DSZ_HALF: ext = {{(ADDR_W-16){raw[15]}}, raw[15:0]};
         default:  ext = raw;
      endcase
   end

   always_comb begin
      if (size_code == DSZ_BYTE)
         AST_BYTE_SIGN: assert (ext[ADDR_W-1] == raw[7]); // R4
   end
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 3,
   parameter int SP_NUM    = 4,
   parameter int MAX_SHIFT = 3
) (
   input  logic                 idx_en,
   input  logic [REG_IDX_W-1:0] idx_sel,
   input  logic [ADDR_W-1:0]    idx_val,
   input  logic [1:0]           scale_code,
   output logic [ADDR_W-1:0]    scaled
);
   localparam int NUM_SHIFTS = MAX_SHIFT + 1;

   generate
      if (SP_NUM >= (1 << REG_IDX_W)) begin : g_bad_sp
         $error("ea_index_scale: SP_NUM outside register space");
      end
      if (NUM_SHIFTS != 4) begin : g_bad_shift
         $error("ea_index_scale: two-bit scale code needs MAX_SHIFT of 3");
      end
   endgenerate

   logic                    idx_live;
   logic [ADDR_W-1:0]       gated;
   logic [ADDR_W-1:0]       shifted [NUM_SHIFTS];

   assign idx_live = idx_en && (idx_sel != REG_IDX_W'(SP_NUM));
   assign gated    = idx_live ? idx_val : '0;

   genvar s;
   generate
      for (s = 0; s < NUM_SHIFTS; s++) begin : g_shift
         assign shifted[s] = gated << s;
      end
   endgenerate

   assign scaled = shifted[scale_code];

   always_comb begin
      if (idx_sel == REG_IDX_W'(SP_NUM))
         AST_SP_NOT_INDEX: assert (scaled == '0); // R6
   end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 3,
   parameter int SP_NUM    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 op_kind,
   input  logic                 base_en,
   input  logic [ADDR_W-1:0]    base_val,
   input  logic                 index_en,
   input  logic [REG_IDX_W-1:0] index_sel,
   input  logic [ADDR_W-1:0]    index_val,
   input  logic [1:0]           scale_code,
   input  logic [1:0]           disp_size,
   input  logic [ADDR_W-1:0]    disp_raw,
   output logic                 out_valid,
   output logic [ADDR_W-1:0]    ea_out,
   output logic                 mem_req,
   output logic                 wb_en,
   output logic [ADDR_W-1:0]    wb_val
);
   import ea_pkg::*;

   logic [ADDR_W-1:0] disp_term;
   logic [ADDR_W-1:0] index_term;
   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] sum;
   logic              valid_q;
   op_kind_e          kind_q;
   logic [ADDR_W-1:0] ea_q;

   ea_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
      .size_code (disp_size),
      .raw       (disp_raw),
      .ext       (disp_term)
   );

   ea_index_scale #(
      .ADDR_W    (ADDR_W),
      .REG_IDX_W (REG_IDX_W),
      .SP_NUM    (SP_NUM),
      .MAX_SHIFT (3)
   ) u_idx (
      .idx_en     (index_en),
      .idx_sel    (index_sel),
      .idx_val    (index_val),
      .scale_code (scale_code),
      .scaled     (index_term)
   );

   assign base_term = base_en ? base_val : '0;
   assign sum       = disp_term + base_term + index_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         kind_q  <= OP_MEM;
         ea_q    <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            kind_q <= op_kind_e'(op_kind);
            ea_q   <= sum;
         end
      end
   end

   assign out_valid = valid_q;
   assign ea_out    = ea_q;
   assign mem_req   = valid_q && (kind_q == OP_MEM);
   assign wb_en     = valid_q && (kind_q == OP_ADDR);
   assign wb_val    = ea_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!mem_req && !wb_en)); // R1
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_MEM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_kind) |=> (mem_req && !wb_en)); // R7
   AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_kind) |=> (wb_en && !mem_req && wb_val == ea_out)); // R8
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && wb_en)); // R9
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_kind = 1'b0;
   logic        base_en = 1'b0;
   logic [31:0] base_val = '0;
   logic        index_en = 1'b0;
   logic [2:0]  index_sel = '0;
   logic [31:0] index_val = '0;
   logic [1:0]  scale_code = '0;
   logic [1:0]  disp_size = '0;
   logic [31:0] disp_raw = '0;
   logic        out_valid, mem_req, wb_en;
   logic [31:0] ea_out, wb_val;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ea_gen uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
      .base_en(base_en), .base_val(base_val), .index_en(index_en),
      .index_sel(index_sel), .index_val(index_val), .scale_code(scale_code),
      .disp_size(disp_size), .disp_raw(disp_raw), .out_valid(out_valid),
      .ea_out(ea_out), .mem_req(mem_req), .wb_en(wb_en), .wb_val(wb_val)
   );

   typedef struct packed {
      logic        op;
      logic        ben;
      logic [31:0] bval;
      logic        ien;
      logic [2:0]  isel;
      logic [31:0] ival;
      logic [1:0]  sc;
      logic [1:0]  dsz;
      logic [31:0] disp;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 32'h0000F000, 1'b0, 3'd1, 32'h0,        2'd0, 2'b01, 32'h08,       32'h0000F008}, // R4 byte disp
      '{1'b0, 1'b1, 32'h0000F000, 1'b1, 3'd1, 32'h100,      2'd0, 2'b00, 32'h0,        32'h0000F100}, // R5 x1
      '{1'b0, 1'b1, 32'h0000F000, 1'b1, 3'd1, 32'h100,      2'd2, 2'b00, 32'h0,        32'h0000F400}, // R5 x4
      '{1'b0, 1'b0, 32'h0,        1'b1, 3'd2, 32'h0000F000, 2'd1, 2'b11, 32'h80,       32'h0001E080}, // R3 no base, x2
      '{1'b1, 1'b1, 32'h104,      1'b0, 3'd0, 32'h0,        2'd0, 2'b01, 32'hFC,       32'h00000100}, // R4 negative byte
      '{1'b0, 1'b1, 32'h1000,     1'b1, 3'd6, 32'h10,       2'd3, 2'b10, 32'h8000,     32'hFFFF9080}, // R5 x8, R4 half
      '{1'b0, 1'b1, 32'h200,      1'b1, 3'd4, 32'h55,       2'd0, 2'b00, 32'h0,        32'h00000200}, // R6 SP index
      '{1'b0, 1'b1, 32'hFFFFFFF0, 1'b0, 3'd0, 32'h0,        2'd0, 2'b01, 32'h20,       32'h00000010}, // R10 wrap
      '{1'b1, 1'b1, 32'h3,        1'b1, 3'd3, 32'h3,        2'd2, 2'b01, 32'h07,       32'h00000016}, // R8 address-only
      '{1'b0, 1'b1, 32'h40,       1'b0, 3'd1, 32'h77,       2'd3, 2'b00, 32'h1234,     32'h00000040}, // R3 absent disp/index
      '{1'b1, 1'b0, 32'h999,      1'b0, 3'd0, 32'h0,        2'd0, 2'b01, 32'hABCD0012, 32'h00000012}  // R4 upper bits ignored
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      in_valid   = 1'b1;
      op_kind    = v.op;
      base_en    = v.ben;
      base_val   = v.bval;
      index_en   = v.ien;
      index_sel  = v.isel;
      index_val  = v.ival;
      scale_code = v.sc;
      disp_size  = v.dsz;
      disp_raw   = v.disp;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
      check("R1 mem_req in reset",   {31'b0, mem_req},   32'd0);
      check("R1 wb_en in reset",     {31'b0, wb_en},     32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(negedge clk);
         check($sformatf("R2 vec %0d out_valid", i), {31'b0, out_valid}, 32'd1);
         check($sformatf("R2 vec %0d ea_out", i), ea_out, VECS[i].exp);
         check($sformatf("R7 vec %0d mem_req", i), {31'b0, mem_req}, {31'b0, ~VECS[i].op});
         check($sformatf("R8 vec %0d wb_en", i), {31'b0, wb_en}, {31'b0, VECS[i].op});
         check($sformatf("R9 vec %0d single action", i), {31'b0, mem_req & wb_en}, 32'd0);
         if (VECS[i].op) check($sformatf("R8 vec %0d wb_val", i), wb_val, VECS[i].exp);
      end

      // R2: idle cycle drops valid and strobes
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
      check("R1 idle mem_req",   {31'b0, mem_req},   32'd0);
      check("R1 idle wb_en",     {31'b0, wb_en},     32'd0);

      // R10: largest terms wrap: FFFFFFFF + FFFFFFFF*8 + FFFFFFFF(word disp)
      apply('{1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 3'd7, 32'hFFFFFFFF, 2'd3, 2'b11, 32'hFFFFFFFF, 32'hFFFFFFF6});
      @(negedge clk);
      check("R10 max wrap", ea_out, 32'hFFFFFFF6);

      // R6: SP index with x8 scale still contributes nothing
      apply('{1'b1, 1'b0, 32'h0, 1'b1, 3'd4, 32'h1000, 2'd3, 2'b00, 32'h0, 32'h0});
      @(negedge clk);
      check("R6 SP index scaled", wb_val, 32'h0);

      // R1: reset in the middle of traffic
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset out_valid", {31'b0, out_valid}, 32'd0);
      check("R1 mid-run reset wb_en",     {31'b0, wb_en},     32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule